// File: doc/BRIEF.md
# Caption Line Serializer

This block places two caption or extended-data bytes on one chosen vertical-blanking line of each field. Software hands it a byte pair for a given field over a small valid/ready stream. When the video timing reaches the target line and a fixed horizontal start pixel, the block drives a burst as a two-level code for the downstream DAC path. The burst is a clock run-in of seven high/low cycles, the start pattern 0, 0, 1, then the first byte and the second byte, each least significant bit first.

Bit timing is locked to 32 bits per line. A phase accumulator adds 32 on every pixel clock and wraps at the samples-per-line value, so the line period is exact in both the 60 Hz and 50 Hz line standards. Each field has its own buffered pair. When software has not supplied a fresh pair for a field, that field's line carries the null pair 0x80, 0x80.

Back-pressure: `pair_ready` reflects the buffer of the field named by `pair_field`. A pair is taken on a clock edge where `pair_valid` and `pair_ready` are both high. The buffer stays full, and `pair_ready` stays low for that field, until the field's caption line consumes it. Writes offered while the buffer is full are not taken and have no effect.

Top module: `caption_line_serializer`

## Requirements
- R1: After reset `cc_active` is 0, `cc_level` equals the low code (240), and `pair_ready` is 1 for both fields.
- R2: A pair is accepted only on an edge with `pair_valid` and `pair_ready` high. `pair_ready` then stays 0 for that field until its line is sent. A pair offered while the field's buffer is full is dropped, and the held pair is the one sent.
- R3: A burst starts only when `line_num` equals 21 plus `line_ofs`, `hpos` equals 260, the current field is enabled and no burst is running.
- R4: The burst opens with seven run-in cycles. Each is one half-bit high followed by one half-bit low, so the first half-bit is high.
- R5: After the run-in come the bits 0, 0, 1. Then follow bits 0..7 of the first byte (`pair_data[7:0]`) and bits 0..7 of the second byte (`pair_data[15:8]`).
- R6: n clocks after the start edge, the half-bit slot index is floor(64*n/S). S is 1716 when `mode_50` is 0 and 1728 when it is 1.
- R7: If no pair is pending for the field, its line carries 0x80 and 0x80. A pending pair is consumed by its line.
- R8: A 0 bit drives code 240 (0 IRE) and a 1 bit drives code 512 (about 50 IRE). Outside a burst the code is 240.
- R9: `cc_active` is high for exactly 52 half-bit slots (run-in through last data bit), then returns to 0.
- R10: Each field sends only its own pair. Sending one field's line leaves the other field's pending pair untouched.
- R11: A field whose `field_en` bit is 0 sends nothing on the target line, and its pending pair stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_num | input | 10 | Current line number within the field |
| field_id | input | 1 | Current field (0 or 1) |
| hpos | input | 11 | Horizontal pixel counter |
| mode_50 | input | 1 | 1 selects 50 Hz line length (1728 samples), 0 selects 1716 |
| field_en | input | 2 | Per-field caption enable |
| line_ofs | input | 3 | Added to line 21 to form the target line |
| pair_valid | input | 1 | Byte pair offered |
| pair_field | input | 1 | Field the offered pair belongs to |
| pair_data | input | 16 | Byte pair, first byte in [7:0] |
| pair_ready | output | 1 | Buffer of `pair_field` can take a pair |
| cc_active | output | 1 | High from run-in start through last data bit |
| cc_level | output | 10 | Output level code |

## Verification
The hardest case to reach is a field whose buffer is full while the other field's line runs, with the field disabled or a write offered against the full buffer. Only line ordering at the ports shows whether held data survived. The bench fills both buffers, sends one field's line, and probes `pair_ready` and a dropped write before sending the held field. It then compares every clock of that burst against waveforms computed from the slot formula. Both line lengths are swept this way, so an accumulator wrap error shows up as a slot boundary shifted by one clock.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef logic [7:0] cc_byte_t;

  typedef struct packed {
    cc_byte_t second;
    cc_byte_t first;
  } cc_pair_t;

  localparam cc_pair_t CC_NULL_PAIR = '{second: 8'h80, first: 8'h80};
  localparam int CC_RUNIN_SLOTS = 14;
  localparam int CC_FRAME_BITS  = 19;
  localparam int CC_TOTAL_SLOTS = CC_RUNIN_SLOTS + 2 * CC_FRAME_BITS;
endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
  parameter int SPL_A = 1716,
  parameter int SPL_B = 1728,
  parameter int STEP  = 32,
  localparam int SPL_MAX = (SPL_A > SPL_B) ? SPL_A : SPL_B,
  localparam int ACC_W   = $clog2(SPL_MAX + STEP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic sel_b,
  output logic half_tick
);
  logic [ACC_W-1:0] acc, acc_n, spl, half;

  assign spl   = sel_b ? ACC_W'(SPL_B) : ACC_W'(SPL_A);
  assign half  = spl >> 1;
  assign acc_n = acc + ACC_W'(STEP);
  assign half_tick = run && ((acc < half && acc_n >= half) || (acc_n >= spl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (clear)      acc <= '0;
    else if (run) begin
      if (acc_n >= spl)  acc <= acc_n - spl;
      else               acc <= acc_n;
    end
  end

  // R6: accumulator always stays below the line length
  p_acc_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc < ACC_W'(SPL_MAX));
endmodule

// File: rtl/cc_pair_buffer.sv
module cc_pair_buffer
  import cc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  cc_pair_t wr_pair,
  input  logic     take,
  output logic     pending,
  output cc_pair_t pair_out
);
  cc_pair_t hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      hold    <= CC_NULL_PAIR;
    end else if (wr_en) begin
      pending <= 1'b1;
      hold    <= wr_pair;
    end else if (take) begin
      pending <= 1'b0;
    end
  end

  assign pair_out = pending ? hold : CC_NULL_PAIR;

  // R2: an accepted write leaves the buffer full
  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending);
  // R11: a held pair stays unchanged until its line takes it
  p_hold_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> (pending && $stable(hold)));
endmodule

// File: rtl/caption_line_serializer.sv
module caption_line_serializer
  import cc_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int HPOS_W    = 11,
  parameter int OFS_W     = 3,
  parameter int LVL_W     = 10,
  parameter int LINE_BASE = 21,
  parameter int START_PIX = 260,
  parameter int SPL_60    = 1716,
  parameter int SPL_50    = 1728,
  parameter int BIT_MUL   = 32,
  parameter int LVL_LO    = 240,
  parameter int LVL_HI    = 512,
  localparam int SLOT_W   = $clog2(CC_TOTAL_SLOTS + 1),
  localparam int IDX_W    = $clog2(CC_FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic [HPOS_W-1:0] hpos,
  input  logic              mode_50,
  input  logic [1:0]        field_en,
  input  logic [OFS_W-1:0]  line_ofs,
  input  logic              pair_valid,
  input  logic              pair_field,
  input  logic [15:0]       pair_data,
  output logic              pair_ready,
  output logic              cc_active,
  output logic [LVL_W-1:0]  cc_level
);
  logic [1:0]              pend;
  cc_pair_t                pair_q [2];
  logic                    start, half_tick, cur_bit;
  logic [SLOT_W-1:0]       slot, slot_off;
  logic [IDX_W-1:0]        bit_idx;
  logic [CC_FRAME_BITS-1:0] frame;
  logic [LINE_W-1:0]       target;

  assign target     = LINE_W'(LINE_BASE) + LINE_W'(line_ofs);
  assign pair_ready = !pend[pair_field];
  assign start      = !cc_active && field_en[field_id] &&
                      (line_num == target) && (hpos == HPOS_W'(START_PIX));

  for (genvar f = 0; f < 2; f++) begin : g_field
    cc_pair_buffer u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (pair_valid && (pair_field == f[0]) && !pend[f]),
      .wr_pair  (cc_pair_t'(pair_data)),
      .take     (start && (field_id == f[0])),
      .pending  (pend[f]),
      .pair_out (pair_q[f])
    );
  end

  cc_bit_timer #(.SPL_A(SPL_60), .SPL_B(SPL_50), .STEP(BIT_MUL)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .run       (cc_active),
    .sel_b     (mode_50),
    .half_tick (half_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_active <= 1'b0;
      slot      <= '0;
      frame     <= '0;
    end else if (start) begin
      cc_active <= 1'b1;
      slot      <= '0;
      frame     <= {pair_q[field_id].second, pair_q[field_id].first, 3'b100};
    end else if (cc_active && half_tick) begin
      if (slot == SLOT_W'(CC_TOTAL_SLOTS - 1)) begin
        cc_active <= 1'b0;
        slot      <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign slot_off = slot - SLOT_W'(CC_RUNIN_SLOTS);
  assign bit_idx  = IDX_W'(slot_off >> 1);

  always_comb begin
    if (slot < SLOT_W'(CC_RUNIN_SLOTS)) cur_bit = ~slot[0];
    else                                cur_bit = frame[bit_idx];
  end

  assign cc_level = (cc_active && cur_bit) ? LVL_W'(LVL_HI) : LVL_W'(LVL_LO);

  // R8: idle output sits at the low code
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_active |-> cc_level == LVL_W'(LVL_LO));
  // R4: a burst opens on a high run-in half
  p_runin_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_active) |-> cc_level == LVL_W'(LVL_HI));
  // R9: slot index never leaves the burst span
  p_slot_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot < SLOT_W'(CC_TOTAL_SLOTS));
  // R3: a burst only begins from the start condition
  p_start_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_active && !start) |=> !cc_active);
endmodule

// File: tb/caption_line_serializer_tb.sv
module caption_line_serializer_tb;
  localparam int LO = 240, HI = 512, START = 260;

  logic        clk = 0, rst_n = 0;
  logic [9:0]  line_num = 0;
  logic        field_id = 0;
  logic [10:0] hpos = 0;
  logic        mode_50 = 0;
  logic [1:0]  field_en = 2'b11;
  logic [2:0]  line_ofs = 0;
  logic        pair_valid = 0, pair_field = 0;
  logic [15:0] pair_data = 0;
  logic        pair_ready, cc_active;
  logic [9:0]  cc_level;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  caption_line_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .line_num(line_num), .field_id(field_id),
    .hpos(hpos), .mode_50(mode_50), .field_en(field_en), .line_ofs(line_ofs),
    .pair_valid(pair_valid), .pair_field(pair_field), .pair_data(pair_data),
    .pair_ready(pair_ready), .cc_active(cc_active), .cc_level(cc_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input int s, input logic [7:0] b0, input logic [7:0] b1);
    int k;
    if (s < 14) return (s % 2 == 0) ? HI : LO;
    k = (s - 14) / 2;
    if (k < 3)  return (k == 2) ? HI : LO;
    if (k < 11) return b0[k-3] ? HI : LO;
    return b1[k-11] ? HI : LO;
  endfunction

  // offer a pair, check whether it was taken (R2)
  task automatic push(input bit f, input logic [7:0] b0, input logic [7:0] b1,
                      input bit exp_take, input string req);
    bit rdy;
    @(negedge clk);
    pair_field = f; pair_data = {b1, b0}; pair_valid = 1;
    #1 rdy = pair_ready;
    @(negedge clk);
    pair_valid = 0;
    check(rdy == exp_take, req, rdy, exp_take);
  endtask

  // drive one target-line crossing and compare every clock of the burst
  task automatic send_line(input bit f, input int line, input bit tx,
                           input logic [7:0] b0, input logic [7:0] b1, input string req);
    int spl, errs, s, ea, el, fa, fe;
    spl = mode_50 ? 1728 : 1716;
    errs = 0; fa = 0; fe = 0;
    @(negedge clk);
    field_id = f; line_num = 10'(line); hpos = 11'(START);
    @(negedge clk);
    hpos = 11'(START + 1);
    for (int n = 0; n < 1500; n++) begin
      s  = (64 * n) / spl;
      ea = (tx && s < 52) ? 1 : 0;
      el = ea ? exp_level(s, b0, b1) : LO;
      if (cc_active !== ea[0] || cc_level !== 10'(el)) begin
        if (errs == 0) begin fa = int'(cc_level) + (cc_active ? 10000 : 0); fe = el + ea * 10000; end
        errs++;
      end
      @(negedge clk);
      hpos = hpos + 1;
    end
    line_num = 0; hpos = 0;
    check(errs == 0, req, fa, fe);
  endtask

  task automatic t_reset;
    check(cc_active == 0, "R1 active", cc_active, 0);
    check(cc_level == 10'(LO), "R1 level", cc_level, LO);
    pair_field = 0; #1 check(pair_ready == 1, "R1 ready0", pair_ready, 1);
    pair_field = 1; #1 check(pair_ready == 1, "R1 ready1", pair_ready, 1);
  endtask

  task automatic t_basic;
    push(0, 8'h41, 8'hC2, 1, "R2 accept");
    pair_field = 0; #1 check(pair_ready == 0, "R2 ready low", pair_ready, 0);
    send_line(0, 21, 1, 8'h41, 8'hC2, "R4 R5 R6 R8 R9 waveform 60Hz");
    pair_field = 0; #1 check(pair_ready == 1, "R7 consumed", pair_ready, 1);
  endtask

  task automatic t_null;
    send_line(0, 21, 1, 8'h80, 8'h80, "R7 null pair");
  endtask

  task automatic t_fields;
    push(0, 8'h15, 8'h2A, 1, "R10 push f0");
    push(1, 8'hF0, 8'h0F, 1, "R10 push f1");
    send_line(1, 21, 1, 8'hF0, 8'h0F, "R10 field1 own pair");
    pair_field = 0; #1 check(pair_ready == 0, "R10 f0 still held", pair_ready, 0);
    push(0, 8'hFF, 8'hFF, 0, "R2 full rejects");
    send_line(0, 21, 1, 8'h15, 8'h2A, "R2 R10 held pair sent");
  endtask

  task automatic t_offset;
    line_ofs = 3'd2;
    send_line(0, 21, 0, 8'h80, 8'h80, "R3 wrong line silent");
    send_line(0, 23, 1, 8'h80, 8'h80, "R3 offset line");
    line_ofs = 0;
  endtask

  task automatic t_disabled;
    field_en = 2'b10;
    push(0, 8'h33, 8'h55, 1, "R11 push");
    send_line(0, 21, 0, 8'h80, 8'h80, "R11 disabled silent");
    pair_field = 0; #1 check(pair_ready == 0, "R11 pair kept", pair_ready, 0);
    field_en = 2'b11;
    send_line(0, 21, 1, 8'h33, 8'h55, "R11 kept pair later sent");
  endtask

  task automatic t_50hz;
    mode_50 = 1;
    push(1, 8'hA5, 8'h3C, 1, "R6 push");
    send_line(1, 21, 1, 8'hA5, 8'h3C, "R6 waveform 50Hz");
    mode_50 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_null();
    t_fields();
    t_offset();
    t_disabled();
    t_50hz();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule